// File: doc/BRIEF.md
# Power Consumption Signature Checker

This block judges a bus from its per-line dissipated-charge measurements. The measurements are typically cycle counts taken while one line at a time is pulsed. After a start pulse it takes one count per line, in line order, and sums them. It then forms a signature element for every line: that line's charge per unit length, divided by the bus-wide charge per unit length. When all lines have the same length this reduces to the line's charge over the average charge. Because the signature is a ratio, a global scaling of all charges by process or supply drift cancels out, and a healthy bus gives elements close to 1.0.

Each element is compared against a per-line calibrated expected value plus or minus a per-line tolerance. Lines whose raw count is zero or at full scale are rejected outright. The summed charge is also checked against an expected average range. That check is needed because a bus with every line shorted together still yields a flat, all-ones signature. The verdict is pass only when nothing is out of range. When adaptation is enabled, a passing device also produces updated calibration means, which a surrounding controller can write back as the next expected values.

Signature elements are unsigned fixed point with 8 fractional bits (256 means 1.0). They are produced one line at a time by a shift-and-subtract divider.

Top module: `psig_checker`

## Requirements
- R1: After reset, `verdict_valid`, `pass`, `upd_valid` and `avg_fail` are 0, every `dev_flags` bit is 0 and every signature element reads 0.
- R2: With equal line lengths, signature element i equals floor(Q_i * sumL * 256 / (L_i * sumQ)). For equal lengths this is Q_i * LINES * 256 / sumQ. Values above 4095 saturate to 4095. Element i occupies bits [12*i+11 : 12*i] of `sig`.
- R3: With unequal lengths taken from `cal_len` (8 bits per line, line i at bits [8*i+7 : 8*i]), each charge is weighted by the inverse of its length using the same formula as R2, and the same saturation applies.
- R4: `dev_flags[i]` is set when element i is below mean_i - tol_i or above mean_i + tol_i. Both bounds are inclusive. Mean and tolerance are 12-bit fields at the same positions as in `sig`.
- R5: `dev_flags[i]` is set when line i's count is 0 or 4095, whatever its signature and tolerance.
- R6: `avg_fail` is set when sumQ < LINES * `avg_lo` or sumQ > LINES * `avg_hi`.
- R7: `pass` is 1 exactly when no `dev_flags` bit is set and `avg_fail` is 0.
- R8: `verdict_valid` rises LINES * (NW + 2) rising edges after the edge that accepts the last count, where NW = 30 at the default parameters. Once high, it and all results stay steady until the next `start`. The edge that samples `start` clears it.
- R9: When `adapt_en` is set and the verdict is pass, `upd_valid` is high for exactly the first verdict cycle. During that cycle, `upd_mean` element i equals mean_i + floor((sig_i - mean_i) / 8).
- R10: `meas_valid` is ignored outside a collection phase. Counts presented after the verdict leave every result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new measurement set |
| meas_valid | input | 1 | A count is present on `meas_q` |
| meas_q | input | 12 | Per-line charge count, line 0 first |
| cal_len | input | 32 | Line lengths, 8 bits per line |
| cal_mean | input | 48 | Expected signature per line |
| cal_tol | input | 48 | Allowed deviation per line |
| avg_lo | input | 12 | Lowest acceptable average count |
| avg_hi | input | 12 | Highest acceptable average count |
| adapt_en | input | 1 | Produce updated means on pass |
| sig | output | 48 | Signature elements |
| dev_flags | output | 4 | Per-line out-of-zone flags |
| avg_fail | output | 1 | Average charge out of range |
| verdict_valid | output | 1 | Results are valid and held |
| pass | output | 1 | Device accepted |
| upd_valid | output | 1 | `upd_mean` is to be written back |
| upd_mean | output | 48 | Adapted calibration means |

## Verification
The embedded properties assume that lengths, means, tolerances and average limits stay steady from a `start` until the following `start`, and that every length is nonzero. The stimulus loads a fresh calibration set only in the cycle that pulses `start`, and never draws a zero length. Idle gaps are inserted at random between counts. After each verdict, stray counts are fed in to confirm that nothing moves.

// File: rtl/psig_checker.sv
module psig_checker #(
  parameter int LINES = 4,
  parameter int QW    = 12,
  parameter int LW    = 8,
  parameter int FRAC  = 8,
  parameter int SW    = 12,
  parameter int ADAPT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                meas_valid,
  input  logic [QW-1:0]       meas_q,
  input  logic [LINES*LW-1:0] cal_len,
  input  logic [LINES*SW-1:0] cal_mean,
  input  logic [LINES*SW-1:0] cal_tol,
  input  logic [QW-1:0]       avg_lo,
  input  logic [QW-1:0]       avg_hi,
  input  logic                adapt_en,
  output logic [LINES*SW-1:0] sig,
  output logic [LINES-1:0]    dev_flags,
  output logic                avg_fail,
  output logic                verdict_valid,
  output logic                pass,
  output logic                upd_valid,
  output logic [LINES*SW-1:0] upd_mean
);

  localparam int IW  = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int SQW = QW + IW;
  localparam int SLW = LW + IW;
  localparam int NW  = QW + SLW + FRAC;
  localparam int DW  = LW + SQW;
  localparam int CW  = $clog2(NW + 1);

  typedef enum logic [2:0] {S_IDLE, S_COL, S_LOAD, S_DIV, S_CMP} st_t;

  st_t             state;
  logic [QW-1:0]   q_r   [LINES];
  logic [SW-1:0]   sig_r [LINES];
  logic [SQW-1:0]  sumq;
  logic [IW-1:0]   idx;
  logic [NW-1:0]   nsh, quot;
  logic [DW-1:0]   rem;
  logic [CW-1:0]   cnt;

  logic [SLW-1:0]  suml;
  always_comb begin
    suml = '0;
    for (int i = 0; i < LINES; i++) suml = suml + SLW'(cal_len[i*LW +: LW]);
  end

  logic [QW-1:0] cur_q;
  logic [LW-1:0] cur_len;
  logic [SW-1:0] cur_mean, cur_tol, qsat;
  logic [NW-1:0] num_w;
  logic [DW-1:0] den_w;
  logic [DW:0]   shf, diff_w;
  logic          lo_out, hi_out, bad_q, flag_now, avg_bad, last;
  logic [SQW-1:0] lo_lim, hi_lim;

  assign cur_q    = q_r[idx];
  assign cur_len  = cal_len[idx*LW +: LW];
  assign cur_mean = cal_mean[idx*SW +: SW];
  assign cur_tol  = cal_tol[idx*SW +: SW];
  assign num_w    = (NW'(cur_q) * NW'(suml)) << FRAC;
  assign den_w    = DW'(cur_len) * DW'(sumq);
  assign shf      = {rem, nsh[NW-1]};
  assign diff_w   = shf - {1'b0, den_w};
  assign qsat     = (|quot[NW-1:SW]) ? '1 : quot[SW-1:0];
  assign lo_out   = ({1'b0, qsat} + {1'b0, cur_tol}) < {1'b0, cur_mean};
  assign hi_out   = {1'b0, qsat} > ({1'b0, cur_mean} + {1'b0, cur_tol});
  assign bad_q    = (cur_q == '0) || (&cur_q);
  assign flag_now = bad_q | lo_out | hi_out;
  assign lo_lim   = SQW'(avg_lo) * SQW'(LINES);
  assign hi_lim   = SQW'(avg_hi) * SQW'(LINES);
  assign avg_bad  = (sumq < lo_lim) || (sumq > hi_lim);
  assign last     = (idx == IW'(LINES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx <= '0;
      sumq <= '0;
      nsh <= '0;
      quot <= '0;
      rem <= '0;
      cnt <= '0;
      dev_flags <= '0;
      avg_fail <= 1'b0;
      verdict_valid <= 1'b0;
      pass <= 1'b0;
      upd_valid <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        q_r[i] <= '0;
        sig_r[i] <= '0;
      end
    end else begin
      upd_valid <= 1'b0;
      if (start) begin
        state <= S_COL;
        idx <= '0;
        sumq <= '0;
        dev_flags <= '0;
        avg_fail <= 1'b0;
        verdict_valid <= 1'b0;
        pass <= 1'b0;
      end else begin
        case (state)
          S_COL: if (meas_valid) begin
            q_r[idx] <= meas_q;
            sumq <= sumq + SQW'(meas_q);
            if (last) begin
              idx <= '0;
              state <= S_LOAD;
            end else idx <= idx + 1'b1;
          end
          S_LOAD: begin
            nsh <= num_w;
            rem <= '0;
            quot <= '0;
            cnt <= CW'(NW);
            state <= S_DIV;
          end
          S_DIV: begin
            nsh <= nsh << 1;
            if (!diff_w[DW]) begin
              rem <= diff_w[DW-1:0];
              quot <= {quot[NW-2:0], 1'b1};
            end else begin
              rem <= shf[DW-1:0];
              quot <= {quot[NW-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) state <= S_CMP;
          end
          S_CMP: begin
            sig_r[idx] <= qsat;
            dev_flags[idx] <= flag_now;
            if (last) begin
              verdict_valid <= 1'b1;
              avg_fail <= avg_bad;
              pass <= ~(|dev_flags | flag_now | avg_bad);
              upd_valid <= adapt_en & ~(|dev_flags | flag_now | avg_bad);
              state <= S_IDLE;
            end else begin
              idx <= idx + 1'b1;
              state <= S_LOAD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SW-1:0] s, m;
    assign s = sig_r[g];
    assign m = cal_mean[g*SW +: SW];
    assign sig[g*SW +: SW] = s;
    assign upd_mean[g*SW +: SW] = (s >= m) ? m + ((s - m) >> ADAPT)
        : m - SW'(({1'b0, m - s} + (SW+1)'((1 << ADAPT) - 1)) >> ADAPT);

    p_badline_r5: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_valid && (q_r[g] == '0 || &q_r[g]) |-> dev_flags[g]);
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && !start |=> verdict_valid && $stable(pass) && $stable(dev_flags) && $stable(sig));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !verdict_valid);

  p_pass_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && pass |-> dev_flags == '0 && !avg_fail);

  p_upd_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> verdict_valid && pass);

  p_upd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);

endmodule

// File: tb/test_psig_checker.sv
module test_psig_checker;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4, QW = 12, LW = 8, SW = 12, FRAC = 8, ADAPT = 3;
  localparam int NW  = QW + LW + 2 + FRAC;
  localparam int LAT = LINES * (NW + 2);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, meas_valid = 1'b0, adapt_en = 1'b0;
  logic [QW-1:0] meas_q = '0, avg_lo = '0, avg_hi = '0;
  logic [LINES*LW-1:0] cal_len = '0;
  logic [LINES*SW-1:0] cal_mean = '0, cal_tol = '0;
  logic [LINES*SW-1:0] sig, upd_mean;
  logic [LINES-1:0] dev_flags;
  logic avg_fail, verdict_valid, pass, upd_valid;

  psig_checker #(.LINES(LINES), .QW(QW), .LW(LW), .FRAC(FRAC), .SW(SW), .ADAPT(ADAPT)) i_psig_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .meas_valid(meas_valid), .meas_q(meas_q),
    .cal_len(cal_len), .cal_mean(cal_mean), .cal_tol(cal_tol), .avg_lo(avg_lo), .avg_hi(avg_hi),
    .adapt_en(adapt_en), .sig(sig), .dev_flags(dev_flags), .avg_fail(avg_fail),
    .verdict_valid(verdict_valid), .pass(pass), .upd_valid(upd_valid), .upd_mean(upd_mean));

  always #(CLK_PERIOD/2) clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int qv[LINES], lv[LINES], mv[LINES], tv[LINES];
  int alo, ahi;
  bit aen;
  int errors = 0, checks = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint e_pcs(int i);
    longint sl = 0, sq = 0, r;
    for (int k = 0; k < LINES; k++) begin sl += lv[k]; sq += qv[k]; end
    if (sq == 0) return 4095;
    r = (longint'(qv[i]) * sl * 256) / (longint'(lv[i]) * sq);
    return (r > 4095) ? 4095 : r;
  endfunction

  function automatic bit e_bad(int i);
    return qv[i] == 0 || qv[i] == 4095;
  endfunction

  function automatic bit e_flag(int i);
    longint p = e_pcs(i);
    return e_bad(i) || (p + tv[i] < mv[i]) || (p > mv[i] + tv[i]);
  endfunction

  function automatic bit e_avg();
    longint sq = 0;
    for (int k = 0; k < LINES; k++) sq += qv[k];
    return sq < LINES * alo || sq > LINES * ahi;
  endfunction

  function automatic longint e_upd(int i);
    longint d = e_pcs(i) - mv[i];
    return (d >= 0) ? mv[i] + d / 8 : mv[i] - ((-d + 7) / 8);
  endfunction

  task automatic run_set();
    longint c0;
    int waited;
    bit eq, exp_pass, sp;
    logic [LINES*SW-1:0] ss;
    @(negedge clk);
    for (int i = 0; i < LINES; i++) begin
      cal_len[i*LW +: LW] = LW'(lv[i]);
      cal_mean[i*SW +: SW] = SW'(mv[i]);
      cal_tol[i*SW +: SW] = SW'(tv[i]);
    end
    avg_lo = QW'(alo); avg_hi = QW'(ahi); adapt_en = aen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(verdict_valid == 1'b0, "R8 cleared by start", verdict_valid, 0);
    c0 = 0;
    for (int i = 0; i < LINES; i++) begin
      repeat ($urandom % 3) @(negedge clk);
      meas_valid = 1'b1; meas_q = QW'(qv[i]);
      c0 = cyc;
      @(negedge clk);
      meas_valid = 1'b0;
    end
    waited = 0;
    while (!verdict_valid && waited < 1000) begin @(negedge clk); waited++; end
    if (!verdict_valid) begin
      chk(1'b0, "R8 verdict timeout", 0, 1);
      return;
    end
    chk(cyc == c0 + 1 + LAT, "R8 latency", cyc - c0 - 1, LAT);
    eq = 1'b1;
    for (int i = 1; i < LINES; i++) if (lv[i] != lv[0]) eq = 1'b0;
    exp_pass = !e_avg();
    for (int i = 0; i < LINES; i++) begin
      chk(sig[i*SW +: SW] == SW'(e_pcs(i)), eq ? "R2 signature" : "R3 weighted signature",
          sig[i*SW +: SW], e_pcs(i));
      chk(dev_flags[i] == e_flag(i), e_bad(i) ? "R5 bad count flag" : "R4 safe zone flag",
          dev_flags[i], e_flag(i));
      if (e_flag(i)) exp_pass = 1'b0;
    end
    chk(avg_fail == e_avg(), "R6 average check", avg_fail, e_avg());
    chk(pass == exp_pass, "R7 verdict", pass, exp_pass);
    chk(upd_valid == (aen && exp_pass), "R9 update strobe", upd_valid, aen && exp_pass);
    if (aen && exp_pass)
      for (int i = 0; i < LINES; i++)
        chk(upd_mean[i*SW +: SW] == SW'(e_upd(i)), "R9 adapted mean", upd_mean[i*SW +: SW], e_upd(i));
    ss = sig; sp = pass;
    @(negedge clk);
    chk(verdict_valid == 1'b1 && pass == sp, "R8 verdict held", verdict_valid, 1);
    chk(upd_valid == 1'b0, "R9 single cycle strobe", upd_valid, 0);
    repeat (3) begin
      meas_valid = 1'b1; meas_q = QW'($urandom);
      @(negedge clk);
    end
    meas_valid = 1'b0;
    @(negedge clk);
    chk(sig == ss && pass == sp && verdict_valid, "R10 stray counts ignored", sig == ss, 1);
  endtask

  task automatic set_flat(int q, int l, int m, int t);
    for (int i = 0; i < LINES; i++) begin qv[i] = q; lv[i] = l; mv[i] = m; tv[i] = t; end
    alo = 10; ahi = 3000; aen = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 200000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk(verdict_valid == 0 && pass == 0 && upd_valid == 0 && avg_fail == 0, "R1 reset outputs", verdict_valid, 0);
    chk(sig == '0 && dev_flags == '0, "R1 reset signature", sig == '0, 1);
    rst_n = 1'b1;

    set_flat(100, 16, 256, 10);
    mv[0] = 246; mv[1] = 266; mv[2] = 245; mv[3] = 267;
    run_set();

    set_flat(200, 16, 256, 4095);
    qv[0] = 0;
    run_set();
    set_flat(200, 16, 256, 4095);
    qv[2] = 4095;
    run_set();

    set_flat(3000, 16, 256, 46);
    ahi = 2000;
    run_set();

    set_flat(100, 255, 256, 46);
    lv[0] = 1;
    run_set();

    set_flat(300, 20, 256, 46);
    qv[1] = 310; mv[2] = 250; mv[3] = 270; aen = 1'b1;
    run_set();

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(verdict_valid == 1'b0, "R8 restart clears verdict", verdict_valid, 0);

    for (int n = 0; n < 40; n++) begin
      int k = 64 + int'($urandom % 177);
      bit eq = $urandom % 2;
      for (int i = 0; i < LINES; i++) begin
        int base;
        lv[i] = eq ? 16 : 8 + int'($urandom % 248);
        base = lv[i] * k / 16;
        qv[i] = base + base * (int'($urandom % 9) - 4) / 100;
        if (qv[i] < 1) qv[i] = 1;
        if (qv[i] > 4094) qv[i] = 4094;
        mv[i] = 256; tv[i] = 46;
      end
      case ($urandom % 8)
        0: qv[$urandom % LINES] = 0;
        1: qv[$urandom % LINES] = 4095;
        2: begin int j = $urandom % LINES; qv[j] = qv[j] / 2 + 1; end
        3: begin int j = $urandom % LINES; qv[j] = (qv[j] * 3 / 2 > 4094) ? 4094 : qv[j] * 3 / 2; end
        default: ;
      endcase
      alo = 20 + int'($urandom % 40);
      ahi = 1500 + int'($urandom % 2500);
      aen = $urandom % 2;
      run_set();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule